// File: doc/BRIEF.md
# Nibble Nonvolatile RAM with Supply-Fail Store

This block holds one 4-bit value at a single address. A host reaches it through a small parallel port: a select strobe marks a request as valid, a write strobe and a read strobe choose what it does, and the block answers with a ready flag. The stored value is also driven onto four dedicated output pins at all times, so external logic can be steered by it directly.

A nonvolatile shadow copy sits beside the working value. When the low-voltage flag rises, the block snapshots the working value and copies it into the shadow over a fixed, parameterised number of cycles. During that time a busy status is high. The copy always runs to the end, even if the flag drops before then. At power-up reset the working value and the output pins are reloaded from the shadow, and no access is accepted until that reload is finished. The block has no link to any other memory on the chip.

Back-pressure rules: a request is valid in any cycle where `acc_sel` is high. It is taken only in a cycle where `acc_ready` is also high. A request made while `acc_ready` is low has no effect and is not held for later. `acc_ready` is low while the reload after reset is in progress and in every cycle where `lv_flag` is high.

Top module: `nvn_nibble_ram`

## Requirements
- R1: After `rst_n` is released, `acc_ready` stays low for RECALL_CYC clock edges. After that, `out_pins` equal the shadow contents. On the very first power-up the shadow contents are SHADOW_INIT.
- R2: A write is taken at a clock edge where `acc_sel`, `acc_wr` and `acc_ready` are all high. From that edge on, `out_pins` equal `acc_wdata`.
- R3: In a cycle where `acc_sel` and `acc_rd` are high, `acc_wr` is low and `acc_ready` is high, `rd_valid` is 1 and `rd_data` equals the stored value. In every other cycle `rd_valid` is 0 and `rd_data` is 0.
- R4: `out_pins` always show the stored value, including while a store is running.
- R5: While `lv_flag` is high, `acc_ready` is low. A write attempted then leaves the stored value unchanged, and a read returns `rd_valid` = 0.
- R6: A rising edge of `lv_flag`, sampled at a clock edge while no store is running and the reload is done, raises `store_busy` from that edge on. `store_busy` then stays high for exactly STORE_CYC cycles.
- R7: The store copies into the shadow the value held when the store started. A later reset brings that value back onto `out_pins`.
- R8: The store runs to completion even if `lv_flag` falls part way through. A write taken after the flag falls changes `out_pins`, but it does not change the value being stored.
- R9: A new rising edge of `lv_flag` while `store_busy` is high is ignored. The busy window is not extended and no second store starts.
- R10: A reset with no store since the previous reset reloads the same shadow value as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset; starts the reload from the shadow |
| lv_flag | input | 1 | Low-voltage indication; its rising edge starts a store |
| acc_sel | input | 1 | Request valid (chip select) |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe (output enable) |
| acc_wdata | input | DATA_W | Write data |
| acc_ready | output | 1 | Request is accepted in this cycle |
| rd_valid | output | 1 | `rd_data` is being driven |
| rd_data | output | DATA_W | Read data, 0 when not driven |
| out_pins | output | DATA_W | Continuous copy of the stored value |
| store_busy | output | 1 | Store to the shadow is in progress |

## Verification
Two functions can be active in the same cycle: a store into the shadow, and a host write to the working value. The bench provokes this overlap by dropping `lv_flag` a few cycles into a store and then writing a new value while `store_busy` is still high. It then checks three things. The busy window still lasts exactly STORE_CYC cycles. `out_pins` follow the new write at once. A following reset reloads the snapshot value and not the later write. A second rising edge of `lv_flag` inside the busy window is also used to check that the window is not extended.

// File: rtl/nvn_pkg.sv
package nvn_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_e;
endpackage

// File: rtl/nvn_recall.sv
module nvn_recall #(
  parameter int RECALL_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy,
  output logic load
);
  import nvn_pkg::*;
  localparam int CNT_W = (RECALL_CYC > 1) ? $clog2(RECALL_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RECALL_CYC - 1);

  seq_e             st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SEQ_RUN;
      cnt_q <= '0;
    end else if (st_q == SEQ_RUN) begin
      if (cnt_q == LAST) st_q <= SEQ_IDLE;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy = (st_q == SEQ_RUN);
  assign load = busy && (cnt_q == LAST);

  // R1: once the reload is done it never restarts without a reset
  assert_recall_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);
endmodule

// File: rtl/nvn_port.sv
module nvn_port #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ready,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] nibble,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] nib_q;
  logic              take_wr;

  assign take_wr = sel && wr && ready;

  always_ff @(posedge clk) begin
    if (!rst_n)       nib_q <= '0;
    else if (load)    nib_q <= load_val;
    else if (take_wr) nib_q <= wdata;
  end

  assign nibble   = nib_q;
  assign rd_valid = sel && rd && !wr && ready;

  for (genvar b = 0; b < DATA_W; b++) begin : g_rd_gate
    assign rd_data[b] = rd_valid & nib_q[b];
  end

  // R2: an accepted write lands in the stored value
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_wr && !load) |=> (nibble == $past(wdata)));
  // R5: a request refused by back-pressure leaves the value alone
  assert_blocked_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && !ready && !load) |=> $stable(nibble));
endmodule

// File: rtl/nvn_store.sv
module nvn_store #(
  parameter int                DATA_W      = 4,
  parameter int                STORE_CYC   = 500000,
  parameter logic [DATA_W-1:0] SHADOW_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lv_flag,
  input  logic              arm,
  input  logic [DATA_W-1:0] nibble,
  output logic              busy,
  output logic [DATA_W-1:0] shadow
);
  import nvn_pkg::*;
  localparam int CNT_W = (STORE_CYC > 1) ? $clog2(STORE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STORE_CYC - 1);

  seq_e              st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              lv_q;
  logic [DATA_W-1:0] snap_q;
  logic [DATA_W-1:0] shadow_q = SHADOW_INIT;
  logic              start;
  logic              finish;

  assign start  = lv_flag && !lv_q && arm && (st_q == SEQ_IDLE);
  assign finish = (st_q == SEQ_RUN) && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      lv_q   <= 1'b1;
      snap_q <= '0;
    end else begin
      lv_q <= lv_flag;
      if (start) begin
        st_q   <= SEQ_RUN;
        cnt_q  <= '0;
        snap_q <= nibble;
      end else if (finish) begin
        st_q <= SEQ_IDLE;
      end else if (st_q == SEQ_RUN) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // nonvolatile copy: no reset, survives power cycling
  always_ff @(posedge clk) begin
    if (rst_n && finish) shadow_q <= snap_q;
  end

  assign busy   = (st_q == SEQ_RUN);
  assign shadow = shadow_q;

  // R6: a qualified rising edge starts a store on the next cycle
  assert_store_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_flag && !lv_q && arm && !busy) |=> busy);
  // R10: the shadow only moves at the end of a store
  assert_shadow_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(shadow));
  // R9: an edge inside the busy window does not restart the count
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !finish) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/nvn_nibble_ram.sv
module nvn_nibble_ram #(
  parameter int                DATA_W      = 4,
  parameter int                STORE_CYC   = 500000,
  parameter int                RECALL_CYC  = 4,
  parameter logic [DATA_W-1:0] SHADOW_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lv_flag,
  input  logic              acc_sel,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              acc_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] out_pins,
  output logic              store_busy
);
  logic              rec_busy;
  logic              rec_load;
  logic [DATA_W-1:0] nib;
  logic [DATA_W-1:0] shadow;

  assign acc_ready = !lv_flag && !rec_busy;

  nvn_recall #(.RECALL_CYC(RECALL_CYC)) u_recall (
    .clk(clk), .rst_n(rst_n), .busy(rec_busy), .load(rec_load)
  );

  nvn_port #(.DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .sel(acc_sel), .wr(acc_wr), .rd(acc_rd),
    .wdata(acc_wdata), .ready(acc_ready), .load(rec_load), .load_val(shadow),
    .nibble(nib), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  nvn_store #(.DATA_W(DATA_W), .STORE_CYC(STORE_CYC), .SHADOW_INIT(SHADOW_INIT)) u_store (
    .clk(clk), .rst_n(rst_n), .lv_flag(lv_flag), .arm(!rec_busy),
    .nibble(nib), .busy(store_busy), .shadow(shadow)
  );

  assign out_pins = nib;
endmodule

// File: tb/tb_nvn_nibble_ram.sv
module tb_nvn_nibble_ram;
  localparam int DW = 4;
  localparam int SC = 40;
  localparam int RC = 3;
  localparam logic [DW-1:0] SINIT = 4'hA;

  logic clk = 0, rst_n = 0, lv = 0, sel = 0, wr = 0, rd = 0;
  logic [DW-1:0] wd = '0;
  logic ready, rv, busy;
  logic [DW-1:0] rdat, pins;

  int checks = 0, fails = 0, busy_seen = 0;
  bit done = 0;
  logic [DW-1:0] exp_nib, exp_shadow;

  always #5 clk = ~clk;

  nvn_nibble_ram #(.DATA_W(DW), .STORE_CYC(SC), .RECALL_CYC(RC), .SHADOW_INIT(SINIT)) dut (
    .clk(clk), .rst_n(rst_n), .lv_flag(lv), .acc_sel(sel), .acc_wr(wr), .acc_rd(rd),
    .acc_wdata(wd), .acc_ready(ready), .rd_valid(rv), .rd_data(rdat),
    .out_pins(pins), .store_busy(busy)
  );

  function automatic logic exp_rv(input logic s, w, r, l);
    return s && r && !w && !l;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, w, r, input logic [DW-1:0] d, input logic l);
    logic e;
    @(negedge clk);
    sel = s; wr = w; rd = r; wd = d; lv = l;
    #1;
    e = exp_rv(s, w, r, l);
    check("R5 ready", int'(ready), int'(!l));
    check("R3 rd_valid", int'(rv), int'(e));
    check("R3 rd_data", int'(rdat), e ? int'(exp_nib) : 0);
    check("R4 out_pins", int'(pins), int'(exp_nib));
    if (busy) busy_seen++;
    @(posedge clk);
    if (s && w && !l) exp_nib = d;
  endtask

  task automatic do_reset(input string req);
    int n;
    @(negedge clk);
    rst_n = 0; sel = 0; wr = 0; rd = 0; lv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    n = 0;
    #1;
    while (!ready && n < 50) begin
      @(posedge clk); #1; n++;
    end
    check({req, " recall cycles"}, n, RC);
    exp_nib = exp_shadow;
    check({req, " recalled pins"}, int'(pins), int'(exp_shadow));
  endtask

  // store test: lv pattern selected by mode; returns after window
  task automatic store_run(input int mode, input logic [DW-1:0] late_w);
    logic l;
    busy_seen = 0;
    cyc(0, 0, 0, '0, 1);
    for (int i = 0; i < SC + 10; i++) begin
      l = 1;
      if (mode == 1) l = (i < 4) ? 1'b1 : 1'b0;
      if (mode == 2) l = (i < 3 || i > 5) ? 1'b1 : 1'b0;
      if (mode == 1 && i == 6) cyc(1, 1, 0, late_w, l);
      else if (i % 3 == 0) cyc(1, 1, 0, ~exp_nib, l);
      else cyc(1, 0, 1, '0, l);
    end
    cyc(0, 0, 0, '0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    exp_shadow = SINIT;
    exp_nib = '0;
    // R1: first power-up reload from the initial shadow
    do_reset("R1");
    check("R3 idle rd_data", int'(rdat), 0);
    check("R6 idle busy", int'(busy), 0);

    // R2 R3 R4: random accesses with supply good
    for (int i = 0; i < 300; i++) begin
      logic s, w, r;
      s = 1'($urandom % 2); w = 1'($urandom % 2); r = 1'($urandom % 2);
      cyc(s, w, r, DW'($urandom), 0);
    end
    cyc(1, 1, 1, 4'h5, 0);              // R2: write with read strobe also high
    cyc(1, 0, 1, '0, 0);                // R3: read back
    check("R2 write lands", int'(pins), 5);

    // R5: low voltage blocks accesses (no store here: edge gated by sequence below)
    // R6 R7: plain store with flag held high
    exp_shadow = exp_nib;
    store_run(0, '0);
    check("R6 busy length", busy_seen, SC);
    check("R5 value kept under low voltage", int'(pins), int'(exp_shadow));
    do_reset("R7");

    // R8: flag drops mid-store, late write after it
    cyc(1, 1, 0, 4'h3, 0);
    exp_shadow = 4'h3;
    store_run(1, 4'hC);
    check("R8 busy length", busy_seen, SC);
    do_reset("R8");

    // R9: second rise inside the busy window
    cyc(1, 1, 0, 4'h9, 0);
    exp_shadow = 4'h9;
    store_run(2, '0);
    check("R9 busy not extended", busy_seen, SC);
    do_reset("R9");

    // R10: reset again without any store
    for (int i = 0; i < 20; i++) cyc(1, 1, 0, DW'($urandom), 0);
    do_reset("R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule